// File: doc/BRIEF.md
# ROM Shadow and Lock Cycle Router

This block sits on the memory request path and decides, for each request, which back end serves it: main DRAM, the boot ROM, or the non-DRAM space (video buffer, device memory, memory-mapped I/O). A fixed window of low memory is split into equal shadowable segments. Each segment has its own read-select and write-select bit, so reads and writes to one segment may land on different targets. Firmware can therefore stream ROM contents into DRAM (reads from ROM, writes to DRAM) and then run from the DRAM copy with writes sent back to ROM, which leaves the copy read-only.

The same decision also screens locked (atomic) cycles. A locked request is allowed only when its final target is DRAM. Any locked request that resolves to ROM or to non-DRAM space is flagged with an error in the same response. The decision is registered, so the response appears one clock after the request.

Top module: `rom_shadow_router`

## Requirements
- R1: During and right after synchronous active-low reset, `rsp_valid` and `rsp_lock_err` are 0.
- R2: `rsp_valid` equals `req_valid` from the previous clock edge, and `rsp_target`/`rsp_lock_err` describe that same request (one cycle of latency).
- R3: Shadow segment i covers byte addresses 0xC0000 + i*0x4000 through 0xC0000 + i*0x4000 + 0x3FFF, i = 0..7. For that segment, `shadow_ctrl[2*i+1]` is the read select and `shadow_ctrl[2*i]` is the write select. Only segment i's own bits affect a request to it.
- R4: A read to a shadow segment goes to DRAM (`rsp_target` = 0) when its read select is 1, and to ROM (`rsp_target` = 1) when it is 0.
- R5: A write to a shadow segment goes to DRAM (0) when its write select is 1, and to ROM (1) when it is 0. A write to ROM is still issued as a valid response with target 1, not dropped.
- R6: Reads and writes to the same segment are routed independently. Read select 0 with write select 1 sends reads to ROM and writes to DRAM. Read select 1 with write select 0 sends reads to DRAM and writes to ROM.
- R7: Addresses 0xA0000 through 0xBFFFF (video window) go to non-DRAM space (`rsp_target` = 2), whatever the controls.
- R8: Any other address goes to DRAM (0) when it is below `dram_limit` and to non-DRAM space (2) otherwise. The shadow window and the video window take priority over `dram_limit`.
- R9: A valid locked request raises `rsp_lock_err` exactly when its resolved target is not DRAM. Unlocked requests never raise it.
- R10: `rsp_lock_err` is 0 in any cycle where `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Request is part of a locked cycle |
| shadow_ctrl | input | 16 | Per-segment {read select, write select} pairs |
| dram_limit | input | 32 | First address above DRAM for non-shadow addresses |
| rsp_valid | output | 1 | Routing result valid |
| rsp_target | output | 2 | 0 = DRAM, 1 = ROM, 2 = non-DRAM space |
| rsp_lock_err | output | 1 | Locked request aimed at a target other than DRAM |

## Verification
Shadow routing and the lock screen always resolve in the same cycle, because the error depends on the target that the segment's select bits have just chosen. The bench sweeps every segment, every pair of select values, both directions and both lock states, at the first and last byte of each segment. All other segments are loaded with the opposite select values. A locked copy-phase read must report ROM together with an error, while a locked write in the same setting must report DRAM with no error. Both outcomes are predicted in the bench from the address arithmetic and compared with the outputs one cycle after issue.

// File: rtl/shadow_router_pkg.sv
// Shared definitions for the shadow router.
// Assumes a 2-bit target code consumed by downstream steering logic.
package shadow_router_pkg;

    typedef enum logic [1:0] {
        TGT_DRAM  = 2'd0,
        TGT_ROM   = 2'd1,
        TGT_NDRAM = 2'd2
    } target_e;

endpackage

// File: rtl/shadow_addr_decode.sv
// Address classifier: finds which shadow segment (if any) an address hits,
// whether it lies in the video window, and whether it is below the DRAM limit.
// Assumes segments are power-of-two sized, aligned and contiguous.
module shadow_addr_decode #(
    parameter int                ADDR_W         = 32,
    parameter int                SEG_COUNT      = 8,
    parameter int                SEG_BYTES_LOG2 = 14,
    parameter logic [ADDR_W-1:0] SHADOW_BASE    = 32'h000C_0000,
    parameter logic [ADDR_W-1:0] HOLE_BASE      = 32'h000A_0000,
    parameter int                HOLE_BYTES_LOG2 = 17,
    localparam int               IDX_W          = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] dram_limit,
    output logic              in_shadow,
    output logic [IDX_W-1:0]  seg_idx,
    output logic              in_hole,
    output logic              below_limit
);

    localparam logic [ADDR_W-1:0] SEG_FIRST = SHADOW_BASE >> SEG_BYTES_LOG2;
    localparam logic [ADDR_W-1:0] HOLE_TAG  = HOLE_BASE >> HOLE_BYTES_LOG2;

    logic [SEG_COUNT-1:0] seg_hit;
    logic [ADDR_W-1:0]    seg_tag;

    assign seg_tag = addr >> SEG_BYTES_LOG2;

    // One comparator per segment against its own aligned tag.
    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        localparam logic [ADDR_W-1:0] MY_TAG = SEG_FIRST + ADDR_W'(g);
        assign seg_hit[g] = (seg_tag == MY_TAG);
    end

    // Encode the hit vector into a segment index.
    always_comb begin
        seg_idx = '0;
        for (int k = 0; k < SEG_COUNT; k++) begin
            if (seg_hit[k]) seg_idx = IDX_W'(k);
        end
    end

    // Window and limit flags.
    always_comb begin
        in_shadow   = |seg_hit;
        in_hole     = ((addr >> HOLE_BYTES_LOG2) == HOLE_TAG);
        below_limit = (addr < dram_limit);
    end

    // At most one segment may claim an address (R3).
    always_comb begin
        a_r3_single_hit: assert ($onehot0(seg_hit));
    end

endmodule

// File: rtl/shadow_route_select.sv
// Picks the target for one request from the decoded region, the segment's
// read/write select pair and the direction. Priority: shadow, video, limit.
// Assumes ctrl holds {read select, write select} per segment, lowest first.
module shadow_route_select
    import shadow_router_pkg::*;
#(
    parameter int  SEG_COUNT = 8,
    localparam int IDX_W     = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
    localparam int CTRL_W    = 2 * SEG_COUNT
) (
    input  logic              in_shadow,
    input  logic [IDX_W-1:0]  seg_idx,
    input  logic              in_hole,
    input  logic              below_limit,
    input  logic              is_write,
    input  logic [CTRL_W-1:0] ctrl,
    output target_e           target
);

    logic [1:0] pair;
    logic       to_dram;

    // Fetch the selected segment's select pair and pick by direction.
    always_comb begin
        pair    = ctrl[{seg_idx, 1'b0} +: 2];
        to_dram = is_write ? pair[0] : pair[1];
    end

    // Region priority resolution.
    always_comb begin
        if (in_shadow)        target = to_dram ? TGT_DRAM : TGT_ROM;
        else if (in_hole)     target = TGT_NDRAM;
        else if (below_limit) target = TGT_DRAM;
        else                  target = TGT_NDRAM;
    end

endmodule

// File: rtl/lock_screen.sv
// Flags a locked request whose resolved target is not DRAM.
// Assumes the target has already been fully resolved for this request.
module lock_screen
    import shadow_router_pkg::*;
(
    input  logic    valid,
    input  logic    lock,
    input  target_e target,
    output logic    err
);

    // Only DRAM supports locked cycles.
    always_comb begin
        err = valid && lock && (target != TGT_DRAM);
    end

endmodule

// File: rtl/rom_shadow_router.sv
// Top of the shadow router: decodes the request, resolves its target,
// screens locked cycles and registers the result (one cycle of latency).
// Assumes inputs are stable around the clock edge; controls may change
// between requests and take effect on the next sampled request.
module rom_shadow_router
    import shadow_router_pkg::*;
#(
    parameter int                ADDR_W          = 32,
    parameter int                SEG_COUNT       = 8,
    parameter int                SEG_BYTES_LOG2  = 14,
    parameter logic [ADDR_W-1:0] SHADOW_BASE     = 32'h000C_0000,
    parameter logic [ADDR_W-1:0] HOLE_BASE       = 32'h000A_0000,
    parameter int                HOLE_BYTES_LOG2 = 17,
    localparam int               CTRL_W          = 2 * SEG_COUNT,
    localparam int               IDX_W           = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_lock,
    input  logic [CTRL_W-1:0] shadow_ctrl,
    input  logic [ADDR_W-1:0] dram_limit,
    output logic              rsp_valid,
    output logic [1:0]        rsp_target,
    output logic              rsp_lock_err
);

    logic             in_shadow;
    logic [IDX_W-1:0] seg_idx;
    logic             in_hole;
    logic             below_limit;
    target_e          nxt_target;
    logic             nxt_err;

    shadow_addr_decode #(
        .ADDR_W          (ADDR_W),
        .SEG_COUNT       (SEG_COUNT),
        .SEG_BYTES_LOG2  (SEG_BYTES_LOG2),
        .SHADOW_BASE     (SHADOW_BASE),
        .HOLE_BASE       (HOLE_BASE),
        .HOLE_BYTES_LOG2 (HOLE_BYTES_LOG2)
    ) u_decode (
        .addr        (req_addr),
        .dram_limit  (dram_limit),
        .in_shadow   (in_shadow),
        .seg_idx     (seg_idx),
        .in_hole     (in_hole),
        .below_limit (below_limit)
    );

    shadow_route_select #(
        .SEG_COUNT (SEG_COUNT)
    ) u_select (
        .in_shadow   (in_shadow),
        .seg_idx     (seg_idx),
        .in_hole     (in_hole),
        .below_limit (below_limit),
        .is_write    (req_write),
        .ctrl        (shadow_ctrl),
        .target      (nxt_target)
    );

    lock_screen u_lock (
        .valid  (req_valid),
        .lock   (req_lock),
        .target (nxt_target),
        .err    (nxt_err)
    );

    // Response register: one cycle from request to routing result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_target   <= TGT_DRAM;
            rsp_lock_err <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_target   <= nxt_target;
            rsp_lock_err <= nxt_err;
        end
    end

    // R2: the response valid tracks the request valid one cycle later.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10: no error without a valid response.
    a_r10_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_lock_err |-> rsp_valid);
    // R9: unlocked requests never produce an error.
    a_r9_unlocked_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lock) |=> !rsp_lock_err);
    // R9: a DRAM result never carries an error.
    a_r9_dram_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_target == 2'd0) |-> !rsp_lock_err);
    // R7: video window goes to non-DRAM space.
    a_r7_hole_ndram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_hole) |=> (rsp_target == 2'd2));

endmodule

// File: tb/rom_shadow_router_test.sv
module rom_shadow_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_lock = 1'b0;
    logic [15:0] shadow_ctrl = '0;
    logic [31:0] dram_limit = 32'h0800_0000;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic        rsp_lock_err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rom_shadow_router uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_lock     (req_lock),
        .shadow_ctrl  (shadow_ctrl),
        .dram_limit   (dram_limit),
        .rsp_valid    (rsp_valid),
        .rsp_target   (rsp_target),
        .rsp_lock_err (rsp_lock_err)
    );

    // Reference target from the requirement text (R3..R8).
    function automatic logic [1:0] ref_target(logic [31:0] a, logic wr,
                                             logic [15:0] c, logic [31:0] lim);
        int seg;
        logic sel;
        if (a >= 32'hC0000 && a < 32'hE0000) begin
            seg = int'((a - 32'hC0000) >> 14);
            sel = wr ? c[2*seg] : c[2*seg+1];
            return sel ? 2'd0 : 2'd1;
        end
        if (a >= 32'hA0000 && a < 32'hC0000) return 2'd2;
        return (a < lim) ? 2'd0 : 2'd2;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one request, wait for the registered result and compare.
    task automatic issue(string req, logic [31:0] a, logic wr, logic lk);
        logic [1:0] et;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_lock = lk;
        et = ref_target(a, wr, shadow_ctrl, dram_limit);
        @(posedge clk); #1;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " target"}, 32'(rsp_target), 32'(et));
        check({req, " lock_err"}, 32'(rsp_lock_err), 32'(lk && et != 2'd0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        check("R1 reset err", 32'(rsp_lock_err), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3/R4/R5/R6/R9: full sweep, other segments hold the opposite pair.
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                for (int j = 0; j < 8; j++)
                    shadow_ctrl[2*j +: 2] = (j == s) ? 2'(c) : ~2'(c);
                for (int off = 0; off < 2; off++)
                    for (int w = 0; w < 2; w++)
                        for (int l = 0; l < 2; l++)
                            issue("R3 R4 R5 R6 R9 sweep",
                                  32'hC0000 + 32'(s) * 32'h4000 + (off ? 32'h3FFF : 32'h0),
                                  w[0], l[0]);
            end
        end

        // R6: copy phase then run phase on segment 2.
        @(negedge clk); shadow_ctrl = 16'h0; shadow_ctrl[5:4] = 2'b01;
        issue("R6 copy read ROM", 32'hC8010, 1'b0, 1'b0);
        issue("R6 copy write DRAM", 32'hC8010, 1'b1, 1'b0);
        @(negedge clk); shadow_ctrl[5:4] = 2'b10;
        issue("R6 run read DRAM", 32'hC8010, 1'b0, 1'b0);
        issue("R5 protected write to ROM", 32'hC8010, 1'b1, 1'b1);

        // R7: video window edges, controls all ones.
        @(negedge clk); shadow_ctrl = 16'hFFFF;
        issue("R7 hole low", 32'hA0000, 1'b0, 1'b1);
        issue("R7 hole high", 32'hBFFFF, 1'b1, 1'b0);
        issue("R8 below hole", 32'h9FFFF, 1'b0, 1'b1);
        issue("R8 above shadow", 32'hE0000, 1'b1, 1'b1);

        // R8: DRAM limit boundary.
        issue("R8 last DRAM byte", 32'h07FF_FFFF, 1'b0, 1'b1);
        issue("R8 first above limit", 32'h0800_0000, 1'b0, 1'b1);
        issue("R8 mmio top", 32'hFFFF_FFF0, 1'b1, 1'b0);
        @(negedge clk); dram_limit = 32'h0000_0000;
        issue("R8 shadow beats limit", 32'hD4000, 1'b0, 1'b1);
        issue("R8 zero limit", 32'h0001_0000, 1'b0, 1'b0);

        // R2/R10: idle cycle with lock asserted on a non-DRAM address.
        @(negedge clk);
        req_valid = 1'b0; req_lock = 1'b1; req_addr = 32'hA0000;
        @(posedge clk); #1;
        check("R2 idle valid", 32'(rsp_valid), 32'd0);
        check("R10 idle no err", 32'(rsp_lock_err), 32'd0);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int t = 0; t < 20000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule